// File: doc/BRIEF.md
# EEPROM Write-Protect and Status Unit

This block keeps the 8-bit status register of a serial EEPROM and decides, cycle by cycle, whether the write-related commands decoded by a command engine may go ahead. The engine passes in single-cycle strobes for enabling writes, disabling writes, writing the status register (with its data byte) and writing a page of the array (with its page address). The block answers a status write or an array write with an accept or a reject in the same cycle. It tracks the self-timed write cycle that an accepted request starts. The cycle ends when a completion pulse arrives from the array timer.

The block also publishes the address range currently guarded by the two block-select bits, so the array side can show it or use it. The non-volatile bits are plain registers that reset to zero. The serial shift logic and the array storage sit outside this block.

A lock bit in the status register combines with an active-low protect pin to freeze the register. The two can be set in either order. Protection values written by a status write take effect only when that write's cycle completes. Until then, the previous values keep guarding the array and the register.

Top module: `wp_status_unit`

## Requirements
- R1: The status byte is {lock bit b7, b6..b4 reading 0, block-select bits b3:b2, write latch b1, busy b0}. Reset clears every bit and the range output reports no protection.
- R2: A write-enable strobe sets the latch (b1) at the next clock edge. A write-disable strobe clears it.
- R3: A status write is accepted only when the latch is 1, no cycle is running and the register is not hardware-locked. Otherwise it is rejected. The accept or reject output is high in the same cycle as the request strobe.
- R4: The register is hardware-locked while b7 is 1 and the protect pin wpN is 0. This holds whichever of the two became true first, and it ends as soon as wpN is driven to 1.
- R5: A status write changes only b7, b3 and b2, taken from data bits 7, 3 and 2. The new values appear after the edge that samples the completion pulse, and the old values stay in force (in the byte and in the range) while the cycle runs.
- R6: b0 is 1 from the edge after an accepted request until the edge that samples the completion pulse. A completion pulse while no cycle runs has no effect.
- R7: Completion of either kind of cycle clears the latch.
- R8: With 2048 bytes, block-select 01 guards 0x600-0x7FF, 10 guards 0x400-0x7FF and 11 guards 0x000-0x7FF, shown on protActive, protLow and protHigh. Block-select 00 drives protActive to 0.
- R9: An array write is rejected when the start address of the addressed 32-byte page is in the guarded range, when the latch is 0, or when a cycle is running. Otherwise it is accepted.
- R10: A rejected request leaves the status byte, including the latch, unchanged.
- R11: The engine issues at most one command strobe per cycle. When a write-enable coincides with the completion pulse of a running cycle, the clearing wins and the latch ends up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWrEnable | input | 1 | Write-enable command strobe |
| cmdWrDisable | input | 1 | Write-disable command strobe |
| cmdStatusWr | input | 1 | Status-write request strobe |
| statusData | input | 8 | Data byte of the status write |
| cmdArrayWr | input | 1 | Array-write request strobe |
| pageAddr | input | PAGE_W (6) | Page index of the array write |
| wpN | input | 1 | Write-protect pin, active low |
| cycleDone | input | 1 | Self-timed cycle completion pulse |
| statusByte | output | 8 | Status byte for readout |
| statusAccept | output | 1 | Status write accepted |
| statusReject | output | 1 | Status write rejected |
| arrayAccept | output | 1 | Array write accepted |
| arrayReject | output | 1 | Array write rejected |
| protActive | output | 1 | Some region is guarded |
| protLow | output | ADDR_W (11) | First guarded address |
| protHigh | output | ADDR_W (11) | Last guarded address |

## Verification
The hardest state to reach is the hardware lock entered in the second order: the lock bit is written while the pin is low and then takes hold for the next request. Reaching it takes an enable, an accepted status write with the pin low, a completion pulse, and a second enable. The walk then sends a status write with the pin still low and expects a reject. The stimulus table also covers the opposite order and the release by raising the pin. A directed step drives an enable in the same cycle as a completion pulse, to check that the clearing wins.

// File: rtl/wpstat_pkg.sv
package wpstat_pkg;
  // Strobes from the control half to the register half.
  typedef struct packed {
    logic setLatch;
    logic clearLatch;
    logic loadShadow;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/wpstat_ctrl.sv
module wpstat_ctrl
  import wpstat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWrEnable,
  input  logic      cmdWrDisable,
  input  logic      cmdStatusWr,
  input  logic      cmdArrayWr,
  input  logic      wpN,
  input  logic      cycleDone,
  input  logic      latch,
  input  logic      lockBit,
  input  logic      inRegion,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      statusAccept,
  output logic      statusReject,
  output logic      arrayAccept,
  output logic      arrayReject
);
  logic pendStatus;
  logic hwLock;
  logic endCycle;

  assign hwLock   = lockBit && !wpN;
  assign endCycle = cycleDone && busy;

  always_comb begin
    statusAccept = cmdStatusWr && latch && !busy && !hwLock;
    statusReject = cmdStatusWr && !statusAccept;
    arrayAccept  = cmdArrayWr && latch && !busy && !inRegion;
    arrayReject  = cmdArrayWr && !arrayAccept;
  end

  always_comb begin
    strobe.setLatch   = cmdWrEnable;
    strobe.clearLatch = cmdWrDisable || endCycle;
    strobe.loadShadow = statusAccept;
    strobe.commit     = endCycle && pendStatus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      pendStatus <= 1'b0;
    end else if (statusAccept || arrayAccept) begin
      busy       <= 1'b1;
      pendStatus <= statusAccept;
    end else if (endCycle) begin
      busy       <= 1'b0;
      pendStatus <= 1'b0;
    end
  end
endmodule

// File: rtl/wpstat_regs.sv
module wpstat_regs
  import wpstat_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        statusData,
  input  logic [PAGE_W-1:0] pageAddr,
  input  logic              busy,
  output logic              latch,
  output logic              lockBit,
  output logic              inRegion,
  output logic [7:0]        statusByte,
  output logic              protActive,
  output logic [ADDR_W-1:0] protLow,
  output logic [ADDR_W-1:0] protHigh
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  logic [1:0]        blockSel;
  logic              shadowLock;
  logic [1:0]        shadowSel;
  logic [ADDR_W-1:0] pageStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latch <= 1'b0;
    end else if (strobe.clearLatch) begin
      latch <= 1'b0;
    end else if (strobe.setLatch) begin
      latch <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowLock <= 1'b0;
      shadowSel  <= 2'b00;
    end else if (strobe.loadShadow) begin
      shadowLock <= statusData[7];
      shadowSel  <= statusData[3:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBit  <= 1'b0;
      blockSel <= 2'b00;
    end else if (strobe.commit) begin
      lockBit  <= shadowLock;
      blockSel <= shadowSel;
    end
  end

  always_comb begin
    case (blockSel)
      2'b01:   protLow = ADDR_W'(MEM_BYTES - MEM_BYTES / 4);
      2'b10:   protLow = ADDR_W'(MEM_BYTES / 2);
      default: protLow = '0;
    endcase
  end

  assign protHigh   = ADDR_W'(MEM_BYTES - 1);
  assign protActive = (blockSel != 2'b00);
  assign pageStart  = {pageAddr, {OFS_W{1'b0}}};
  assign inRegion   = protActive && (pageStart >= protLow);
  assign statusByte = {lockBit, 3'b000, blockSel, latch, busy};
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wpstat_pkg::*;
#(
  parameter  int MEM_BYTES  = 2048,
  parameter  int PAGE_BYTES = 32,
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int PAGE_W     = ADDR_W - $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEnable,
  input  logic              cmdWrDisable,
  input  logic              cmdStatusWr,
  input  logic [7:0]        statusData,
  input  logic              cmdArrayWr,
  input  logic [PAGE_W-1:0] pageAddr,
  input  logic              wpN,
  input  logic              cycleDone,
  output logic [7:0]        statusByte,
  output logic              statusAccept,
  output logic              statusReject,
  output logic              arrayAccept,
  output logic              arrayReject,
  output logic              protActive,
  output logic [ADDR_W-1:0] protLow,
  output logic [ADDR_W-1:0] protHigh
);
  dpStrobe_t strobe;
  logic      busy;
  logic      latch;
  logic      lockBit;
  logic      inRegion;

  wpstat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWrEnable(cmdWrEnable), .cmdWrDisable(cmdWrDisable),
    .cmdStatusWr(cmdStatusWr), .cmdArrayWr(cmdArrayWr),
    .wpN(wpN), .cycleDone(cycleDone),
    .latch(latch), .lockBit(lockBit), .inRegion(inRegion),
    .strobe(strobe), .busy(busy),
    .statusAccept(statusAccept), .statusReject(statusReject),
    .arrayAccept(arrayAccept), .arrayReject(arrayReject)
  );

  wpstat_regs #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .statusData(statusData), .pageAddr(pageAddr), .busy(busy),
    .latch(latch), .lockBit(lockBit), .inRegion(inRegion),
    .statusByte(statusByte), .protActive(protActive),
    .protLow(protLow), .protHigh(protHigh)
  );
endmodule

// File: rtl/wpstat_checker.sv
module wpstat_checker #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrEnable,
  input logic              cmdWrDisable,
  input logic              cmdStatusWr,
  input logic [7:0]        statusData,
  input logic              cmdArrayWr,
  input logic [PAGE_W-1:0] pageAddr,
  input logic              wpN,
  input logic              cycleDone,
  input logic [7:0]        statusByte,
  input logic              statusAccept,
  input logic              statusReject,
  input logic              arrayAccept,
  input logic              arrayReject,
  input logic              protActive,
  input logic [ADDR_W-1:0] protLow,
  input logic [ADDR_W-1:0] protHigh
);
  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000);

  assert_enable_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrEnable && !cycleDone |=> statusByte[1]);

  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrDisable |=> !statusByte[1]);

  assert_needs_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusAccept |-> statusByte[1] && !statusByte[0]);

  assert_hw_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdStatusWr && statusByte[7] && !wpN |-> statusReject && !statusAccept);

  assert_old_values_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusAccept |=> $stable(statusByte[7:2]));

  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusAccept || arrayAccept |=> statusByte[0]);

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone && statusByte[0] |=> !statusByte[1] && !statusByte[0]);

  assert_array_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    arrayAccept |-> statusByte[1] && !statusByte[0] && !arrayReject);

  assert_reject_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusReject || arrayReject) && !cycleDone |=> $stable(statusByte));

  assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cmdWrEnable, cmdWrDisable, cmdStatusWr, cmdArrayWr}) <= 1);
endmodule

bind wp_status_unit wpstat_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/wp_status_unit_test.sv
module wp_status_unit_test;
  localparam int PERIOD = 10;
  localparam int AW = 11;
  localparam int PW = 6;

  // op: 0 idle, 1 enable, 2 disable, 3 status write, 4 array write, 5 done, 6 enable+done
  typedef struct packed {
    logic [2:0]    op;
    logic [7:0]    data;
    logic [PW-1:0] page;
    logic          wp;
    logic          expAcc;
    logic          expRej;
    logic [7:0]    expStat;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{3'd4, 8'h00, 6'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd9},  // R9 latch clear
    '{3'd3, 8'hFF, 6'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd3},  // R3 latch clear
    '{3'd1, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h02, 4'd2},  // R2
    '{3'd3, 8'h84, 6'h00, 1'b1, 1'b1, 1'b0, 8'h03, 4'd5},  // R5 old bits held
    '{3'd3, 8'h00, 6'h00, 1'b1, 1'b0, 1'b1, 8'h03, 4'd3},  // R3 busy
    '{3'd4, 8'h00, 6'h00, 1'b1, 1'b0, 1'b1, 8'h03, 4'd9},  // R9 busy
    '{3'd5, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h84, 4'd7},  // R7 commit
    '{3'd1, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h86, 4'd2},  // R2
    '{3'd4, 8'h00, 6'h30, 1'b1, 1'b0, 1'b1, 8'h86, 4'd9},  // R9 0x600 guarded
    '{3'd4, 8'h00, 6'h2F, 1'b1, 1'b1, 1'b0, 8'h87, 4'd9},  // R9 0x5E0 free
    '{3'd5, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h84, 4'd7},  // R7 array done
    '{3'd1, 8'h00, 6'h00, 1'b0, 1'b0, 1'b0, 8'h86, 4'd2},  // R2
    '{3'd3, 8'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'h86, 4'd4},  // R4 pin low after bit
    '{3'd3, 8'h08, 6'h00, 1'b1, 1'b1, 1'b0, 8'h87, 4'd4},  // R4 pin high releases
    '{3'd5, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h08, 4'd5},  // R5
    '{3'd1, 8'h00, 6'h00, 1'b0, 1'b0, 1'b0, 8'h0A, 4'd2},  // R2
    '{3'd3, 8'h8C, 6'h00, 1'b0, 1'b1, 1'b0, 8'h0B, 4'd4},  // R4 bit 0, pin low ok
    '{3'd5, 8'h00, 6'h00, 1'b0, 1'b0, 1'b0, 8'h8C, 4'd5},  // R5
    '{3'd1, 8'h00, 6'h00, 1'b0, 1'b0, 1'b0, 8'h8E, 4'd2},  // R2
    '{3'd4, 8'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'h8E, 4'd9},  // R9 whole array
    '{3'd3, 8'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'h8E, 4'd4},  // R4 bit set while pin low
    '{3'd2, 8'h00, 6'h00, 1'b0, 1'b0, 1'b0, 8'h8C, 4'd2},  // R2 disable
    '{3'd3, 8'h00, 6'h00, 1'b1, 1'b0, 1'b1, 8'h8C, 4'd10}, // R10
    '{3'd1, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h8E, 4'd2},  // R2
    '{3'd3, 8'h73, 6'h00, 1'b1, 1'b1, 1'b0, 8'h8F, 4'd5},  // R5 masked bits
    '{3'd5, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd5},  // R5 only b7,b3,b2
    '{3'd1, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h02, 4'd2},  // R2
    '{3'd4, 8'h00, 6'h3F, 1'b1, 1'b1, 1'b0, 8'h03, 4'd9},  // R9 no guard
    '{3'd5, 8'h00, 6'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd6}   // R6 busy drops
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdWrEnable = 1'b0, cmdWrDisable = 1'b0, cmdStatusWr = 1'b0, cmdArrayWr = 1'b0;
  logic [7:0]    statusData = '0;
  logic [PW-1:0] pageAddr = '0;
  logic          wpN = 1'b1;
  logic          cycleDone = 1'b0;
  logic [7:0]    statusByte;
  logic          statusAccept, statusReject, arrayAccept, arrayReject, protActive;
  logic [AW-1:0] protLow, protHigh;

  int checks = 0;
  int fails = 0;
  logic accSeen, rejSeen;

  wp_status_unit uut (
    .clk(clk), .rstN(rstN),
    .cmdWrEnable(cmdWrEnable), .cmdWrDisable(cmdWrDisable),
    .cmdStatusWr(cmdStatusWr), .statusData(statusData),
    .cmdArrayWr(cmdArrayWr), .pageAddr(pageAddr),
    .wpN(wpN), .cycleDone(cycleDone),
    .statusByte(statusByte),
    .statusAccept(statusAccept), .statusReject(statusReject),
    .arrayAccept(arrayAccept), .arrayReject(arrayReject),
    .protActive(protActive), .protLow(protLow), .protHigh(protHigh)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doStep(input logic [2:0] op, input logic [7:0] data,
                        input logic [PW-1:0] page, input logic wp);
    @(negedge clk);
    wpN          = wp;
    statusData   = data;
    pageAddr     = page;
    cmdWrEnable  = (op == 3'd1) || (op == 3'd6);
    cmdWrDisable = (op == 3'd2);
    cmdStatusWr  = (op == 3'd3);
    cmdArrayWr   = (op == 3'd4);
    cycleDone    = (op == 3'd5) || (op == 3'd6);
    #1;
    accSeen = statusAccept || arrayAccept;
    rejSeen = statusReject || arrayReject;
    @(posedge clk);
    #1;
    cmdWrEnable = 1'b0; cmdWrDisable = 1'b0; cmdStatusWr = 1'b0;
    cmdArrayWr = 1'b0; cycleDone = 1'b0;
  endtask

  task automatic setSel(input logic [7:0] data);
    doStep(3'd1, 8'h00, '0, 1'b1);
    doStep(3'd3, data, '0, 1'b1);
    doStep(3'd5, 8'h00, '0, 1'b1);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(statusByte == 8'h00, "R1 reset status", statusByte, 8'h00);
    check(protActive == 1'b0, "R1 reset range", protActive, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doStep(VEC[i].op, VEC[i].data, VEC[i].page, VEC[i].wp);
      check(accSeen == VEC[i].expAcc, $sformatf("R%0d accept row %0d", VEC[i].req, i),
            accSeen, VEC[i].expAcc);
      check(rejSeen == VEC[i].expRej, $sformatf("R%0d reject row %0d", VEC[i].req, i),
            rejSeen, VEC[i].expRej);
      check(statusByte == VEC[i].expStat, $sformatf("R%0d status row %0d", VEC[i].req, i),
            statusByte, VEC[i].expStat);
    end

    // R8 range per block-select value, with the old range held mid-cycle (R5)
    check(protActive == 1'b0, "R8 none guarded", protActive, 0);
    doStep(3'd1, 8'h00, '0, 1'b1);
    doStep(3'd3, 8'h04, '0, 1'b1);
    check(protActive == 1'b0, "R5 range held during cycle", protActive, 0);
    doStep(3'd5, 8'h00, '0, 1'b1);
    check(protActive && protLow == 11'h600, "R8 quarter low", protLow, 11'h600);
    check(protHigh == 11'h7FF, "R8 quarter high", protHigh, 11'h7FF);
    setSel(8'h08);
    check(protActive && protLow == 11'h400, "R8 half low", protLow, 11'h400);
    setSel(8'h0C);
    check(protActive && protLow == 11'h000, "R8 whole low", protLow, 11'h000);

    // R6 completion while idle has no effect
    doStep(3'd5, 8'h00, '0, 1'b1);
    check(statusByte == 8'h0C, "R6 idle done ignored", statusByte, 8'h0C);

    // R11 enable in the same cycle as completion: clearing wins
    doStep(3'd1, 8'h00, '0, 1'b1);
    doStep(3'd3, 8'h00, '0, 1'b1);
    check(statusByte == 8'h0F, "R11 cycle running", statusByte, 8'h0F);
    doStep(3'd6, 8'h00, '0, 1'b1);
    check(statusByte == 8'h00, "R11 clear wins", statusByte, 8'h00);

    // R1 reset in the middle of a running cycle
    setSel(8'h84);
    doStep(3'd1, 8'h00, '0, 1'b1);
    doStep(3'd4, 8'h00, 6'h00, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(statusByte == 8'h00, "R1 reset clears", statusByte, 8'h00);
    check(protActive == 1'b0, "R1 reset range clear", protActive, 0);
    @(negedge clk);
    rstN = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule